// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

This block is a parameterized register with a default width of 4 bits. A two-bit mode input selects what it does on each rising clock edge. It can keep its contents, shift toward the low-order end, shift toward the high-order end, or load a whole parallel word.

- Each shift direction has its own serial input. The bit that moves past the far end of the word is lost.
- The parallel output shows every stored bit. Its top bit is the most significant bit of the word.
- An active-low clear empties the register at once, without waiting for a clock edge.

A designer who wants a rotating register connects the least significant output bit back to the serial input used by the downward shift. The same word then circulates indefinitely.

Top module: `bidir_shift_reg`

## Requirements
- R1: With `mode` = 2'b00, a rising clock edge leaves `parOut` unchanged, whatever the serial and parallel inputs are.
- R2: With `mode` = 2'b01 (shift down), a rising edge makes `parOut` equal to {`serInDown`, old `parOut[W-1:1]`}, and the old `parOut[0]` is discarded.
- R3: With `mode` = 2'b10 (shift up), a rising edge makes `parOut` equal to {old `parOut[W-2:0]`, `serInUp`}, and the old `parOut[W-1]` is discarded.
- R4: With `mode` = 2'b11, a rising edge copies `parIn` into `parOut` bit for bit, with `parIn[W-1]` landing in the high-order position `parOut[W-1]`.
- R5: When `clrN` goes low, `parOut` becomes all zeros at once, with no clock edge needed. After reset, the register starts out empty.
- R6: While `clrN` is low, clock edges do not change `parOut` in any mode. Clear wins over load.
- R7: In a shift, every bit takes its new value from the values the bits held before the edge, so no new value ripples through two positions in one edge.
- R8: With `parOut[0]` wired back to `serInDown` and the mode held at 2'b01, a single 1 moves one place down on each edge and wraps around: 1000, 0100, 0010, 0001, 1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| clrN | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 keep, 01 shift down, 10 shift up, 11 parallel load |
| serInDown | input | 1 | Serial bit that enters the high-order end during a downward shift |
| serInUp | input | 1 | Serial bit that enters the low-order end during an upward shift |
| parIn | input | WIDTH | Parallel load word; bit WIDTH-1 is the high-order bit |
| parOut | output | WIDTH | Stored word; bit WIDTH-1 is the high-order bit |

## Verification
The bench builds the block with its default width of 4. At that width, one vector table can reach both serial entry points and both discarded end bits. A full wrap of a single bit in the rotate setup then takes only four edges. The 4-bit patterns include alternating words such as 1010 and 0101. With those, a shift that rippled through the word, or one that swapped its direction, would show up at once at the outputs.

// File: rtl/bidir_shift_pkg.sv
package bidir_shift_pkg;

  typedef enum logic [1:0] {
    MODE_KEEP = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_UP   = 2'b10,
    MODE_LOAD = 2'b11
  } shiftMode_e;

  // One strobe per action; exactly one is active in each cycle.
  typedef struct packed {
    logic keep;
    logic moveDown;
    logic moveUp;
    logic takePar;
  } stepCmd_t;

endpackage

// File: rtl/bidir_shift_ctrl.sv
module bidir_shift_ctrl
  import bidir_shift_pkg::*;
(
  input  logic       clk,
  input  logic       clrN,
  input  logic [1:0] mode,
  output stepCmd_t   cmd
);

  shiftMode_e modeSel;

  assign modeSel = shiftMode_e'(mode);

  always_comb begin
    cmd = '0;
    unique case (modeSel)
      MODE_KEEP: cmd.keep     = 1'b1;
      MODE_DOWN: cmd.moveDown = 1'b1;
      MODE_UP:   cmd.moveUp   = 1'b1;
      MODE_LOAD: cmd.takePar  = 1'b1;
      default:   cmd.keep     = 1'b1;
    endcase
  end

  // R1 R2 R3 R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!clrN)
    $countones({cmd.keep, cmd.moveDown, cmd.moveUp, cmd.takePar}) == 1);

endmodule

// File: rtl/bidir_shift_dp.sv
module bidir_shift_dp
  import bidir_shift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrN,
  input  stepCmd_t         cmd,
  input  logic             serInDown,
  input  logic             serInUp,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stored
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] nextWord;

  // Each bit slice picks its source from the pre-edge word only.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic fromHigh;
    logic fromLow;
    if (i == MSB) begin : g_top
      assign fromHigh = serInDown;
    end else begin : g_midHigh
      assign fromHigh = stored[i+1];
    end
    if (i == 0) begin : g_bottom
      assign fromLow = serInUp;
    end else begin : g_midLow
      assign fromLow = stored[i-1];
    end
    assign nextWord[i] = cmd.takePar  ? parIn[i] :
                         cmd.moveDown ? fromHigh :
                         cmd.moveUp   ? fromLow  :
                                        stored[i];
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) stored <= '0;
    else       stored <= nextWord;
  end

  // R1
  keep_stable_chk: assert property (@(posedge clk) disable iff (!clrN)
    cmd.keep |=> $stable(stored));

  // R2
  down_shift_chk: assert property (@(posedge clk) disable iff (!clrN)
    cmd.moveDown |=> stored == {$past(serInDown), $past(stored[MSB:1])});

  // R3
  up_shift_chk: assert property (@(posedge clk) disable iff (!clrN)
    cmd.moveUp |=> stored == {$past(stored[MSB-1:0]), $past(serInUp)});

  // R4
  par_load_chk: assert property (@(posedge clk) disable iff (!clrN)
    cmd.takePar |=> stored == $past(parIn));

  // R6
  clear_wins_chk: assert property (@(posedge clk)
    !clrN |-> stored == '0);

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import bidir_shift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic [1:0]       mode,
  input  logic             serInDown,
  input  logic             serInUp,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] parOut
);

  stepCmd_t stepCmd;

  bidir_shift_ctrl u_ctrl (
    .clk  (clk),
    .clrN (clrN),
    .mode (mode),
    .cmd  (stepCmd)
  );

  bidir_shift_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .clrN      (clrN),
    .cmd       (stepCmd),
    .serInDown (serInDown),
    .serInUp   (serInUp),
    .parIn     (parIn),
    .stored    (parOut)
  );

endmodule

// File: tb/bidir_shift_reg_test.sv
module bidir_shift_reg_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int NVEC = 10;

  // {mode[1:0], serInDown, serInUp, parIn[3:0], expected[3:0]}, run from an empty register
  localparam logic [11:0] VEC [NVEC] = '{
    {2'b11, 1'b0, 1'b0, 4'b1010, 4'b1010},  // R4 load
    {2'b00, 1'b1, 1'b1, 4'b0000, 4'b1010},  // R1 keep
    {2'b01, 1'b1, 1'b0, 4'b0000, 4'b1101},  // R2 R7 shift down, serial 1 enters
    {2'b01, 1'b0, 1'b0, 4'b1111, 4'b0110},  // R2 shift down, low bit lost
    {2'b10, 1'b0, 1'b1, 4'b0000, 4'b1101},  // R3 shift up, serial 1 enters
    {2'b10, 1'b1, 1'b0, 4'b0000, 4'b1010},  // R3 R7 shift up, high bit lost
    {2'b11, 1'b1, 1'b1, 4'b0101, 4'b0101},  // R4 load
    {2'b10, 1'b0, 1'b1, 4'b0000, 4'b1011},  // R3 shift up
    {2'b01, 1'b1, 1'b1, 4'b0000, 4'b1101},  // R2 shift down
    {2'b00, 1'b0, 1'b0, 4'b1111, 4'b1101}   // R1 keep ignores parIn
  };

  logic         clk = 1'b0;
  logic         clrN;
  logic [1:0]   mode;
  logic         downDrive;
  logic         serInUp;
  logic         rotateOn;
  logic [W-1:0] parIn;
  logic [W-1:0] parOut;
  wire          serInDown = rotateOn ? parOut[0] : downDrive;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_shift_reg #(.WIDTH(W)) uut (
    .clk       (clk),
    .clrN      (clrN),
    .mode      (mode),
    .serInDown (serInDown),
    .serInUp   (serInUp),
    .parIn     (parIn),
    .parOut    (parOut)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (parOut !== exp) begin
      fails++;
      $display("FAIL %s: parOut=%b expected=%b", req, parOut, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic sd, input logic su,
                      input logic [W-1:0] p);
    @(negedge clk);
    mode = m; downDrive = sd; serInUp = su; parIn = p;
    @(posedge clk);
    #1;
  endtask

  initial begin
    clrN = 1'b0; mode = 2'b00; downDrive = 1'b0; serInUp = 1'b0;
    rotateOn = 1'b0; parIn = '0;
    #1;
    check("R5 reset state", 4'b0000);
    repeat (2) @(posedge clk);
    @(negedge clk) clrN = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      step(VEC[k][11:10], VEC[k][9], VEC[k][8], VEC[k][7:4]);
      check($sformatf("R1-4 vector %0d", k), VEC[k][3:0]);
    end

    // R5: asynchronous clear in the middle of a cycle
    step(2'b11, 1'b0, 1'b0, 4'b1111);
    check("R4 load ones", 4'b1111);
    @(negedge clk) clrN = 1'b0;
    #1;
    check("R5 async clear", 4'b0000);

    // R6: clear holds against load edges
    mode = 2'b11; parIn = 4'b1111;
    repeat (3) @(posedge clk);
    #1;
    check("R6 clear dominates", 4'b0000);
    @(negedge clk) clrN = 1'b1;

    // R7: simultaneous update on an alternating word
    step(2'b11, 1'b0, 1'b0, 4'b0101);
    step(2'b01, 1'b0, 1'b0, 4'b0000);
    check("R7 shift down 0101", 4'b0010);

    // R8: rotate with bit 0 fed back
    step(2'b11, 1'b0, 1'b0, 4'b1000);
    rotateOn = 1'b1;
    step(2'b01, 1'b0, 1'b0, 4'b0000);
    check("R8 rotate 1", 4'b0100);
    step(2'b01, 1'b0, 1'b0, 4'b0000);
    check("R8 rotate 2", 4'b0010);
    step(2'b01, 1'b0, 1'b0, 4'b0000);
    check("R8 rotate 3", 4'b0001);
    step(2'b01, 1'b0, 1'b0, 4'b0000);
    check("R8 rotate wrap", 4'b1000);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule